// File: doc/BRIEF.md
# Quad Flash Read Prefetcher

This block maps a window of serial flash onto a simple read port. The first read request opens a quad-I/O fast-read transaction at the requested byte address. It drives the command byte, the address, the continuation byte and a configurable number of turnaround cycles on four data lines. It then clocks data into a small prefetch queue. The requested byte is returned on `rdata` with a one-cycle `ready` pulse.

Once a byte has been served, chip select stays asserted and the serial clock keeps running. The following bytes therefore land in the queue before anyone asks for them. A request for the next address in sequence is answered from the queue, with no new command on the wire. When the queue is full, the serial clock parks low until a byte is taken.

Chip select is released for one of four reasons:
- a request that breaks the sequence, which flushes the queue and starts a fresh transaction at the new address;
- an enabled idle timeout;
- the abort input;
- a configuration write.

With the "command once" option set, only the first transaction after a configuration write carries the command byte. Later transactions start at the address, because the continuation byte has left the flash in continuous-read state.

Top module: `qspi_xip_prefetch`

## Requirements
- R1: A transaction starts with `cs_n` falling while `sclk` is low. Every nibble is driven MSB-nibble first with `io_oe` high and is sampled by the flash on a rising `sclk`. The order is: the command byte 0xEB as 2 nibbles (when due), the 24-bit address as 6 nibbles, and the continuation byte 0xA0 as 2 nibbles. Then come `cfg_dummy` clock cycles, then data nibbles, high nibble first. Each served byte on `rdata` equals the flash content at the requested address.
- R2: `sclk` only toggles while `cs_n` is low.
- R3: After a byte is served, `cs_n` stays low. Requests for consecutive addresses are served from the queue without a new falling edge on `cs_n`.
- R4: When the queue holds FIFO_DEPTH bytes, `sclk` stays low until a byte is popped. No byte is lost.
- R5: The command byte is sent in every transaction when `cfg_once` is 0. When `cfg_once` is 1, it is sent only in the first transaction after reset or after a configuration write.
- R6: A request whose address differs from the next expected address raises `cs_n` for at least CS_HIGH_CYC cycles and discards the queued bytes. It then starts a new transaction at the requested address.
- R7: With `cfg_to_en` set, `cs_n` rises after `cfg_to_limit` cycles with no request. With it clear, `cs_n` stays low indefinitely.
- R8: A pulse on `abort` or on `cfg_wr` raises `cs_n` on the next clock edge.
- R9: `busy` equals the inverse of `cs_n`. It rises only when a transaction starts and falls only after a timeout, abort, configuration write or sequence break.
- R10: During reset `cs_n` is 1 and `sclk`, `io_oe`, `ready` and `busy` are 0.
- R11: `ready` is a single-cycle pulse and is only given while a request was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe; latches the cfg_* fields and closes any open transaction |
| cfg_once | input | 1 | Send the command byte only once per configuration |
| cfg_dummy | input | DCYC_W | Turnaround clock cycles before data |
| cfg_to_en | input | 1 | Enable the idle timeout |
| cfg_to_limit | input | TO_W | Idle cycles before release |
| abort | input | 1 | Close the open transaction |
| req | input | 1 | Read request, held until ready |
| addr | input | ADDR_W | Byte address of the request |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Returned byte, valid with ready |
| busy | output | 1 | A transaction holds the flash selected |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Flash select, active low |
| io_out | output | 4 | Data lines driven toward the flash |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 4 | Data lines driven by the flash |

## Verification
A lost or skewed nibble counter in the serial engine corrupts the address or continuation byte the flash decodes. The flash model catches this at the end of the header, about a dozen serial clocks after `cs_n` falls, and the returned bytes are then wrong as well. A stale next-address register shows up on the very next request in one of two ways. Either an extra `cs_n` edge appears where a queue hit was due, or the wrong byte comes back. A wrong queue count shows up as `sclk` pulses during the full-queue stall, or as a byte dropped or repeated in a long consecutive run.

// File: rtl/xip_pkg.sv
package xip_pkg;
   typedef enum logic [2:0] {
      LK_IDLE,
      LK_HDR,
      LK_DUMMY,
      LK_DATA,
      LK_GAP
   } link_st_t;
endpackage

// File: rtl/xip_fifo.sv
module xip_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);
   assign head  = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp] <= push_data;
   end

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> !full); // R4
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> !empty); // R3
endmodule

// File: rtl/xip_idle_timer.sv
module xip_idle_timer #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic [TO_W-1:0] limit,
   input  logic            run,
   output logic            expired
);
   logic [TO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (cnt != limit)  cnt <= cnt + 1'b1;
   end

   assign expired = enable && run && (cnt == limit);
endmodule

// File: rtl/xip_link.sv
module xip_link
   import xip_pkg::*;
#(
   parameter int         ADDR_W      = 24,
   parameter int         DCYC_W      = 5,
   parameter int         CS_HIGH_CYC = 2,
   parameter logic [7:0] READ_CMD    = 8'hEB,
   parameter logic [7:0] MODE_BITS   = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              send_cmd,
   input  logic [DCYC_W-1:0] dummy,
   input  logic              release_req,
   input  logic              room,
   input  logic [3:0]        io_in,
   output logic              sclk,
   output logic              cs_n,
   output logic [3:0]        io_out,
   output logic              io_oe,
   output logic              push,
   output logic [7:0]        push_data,
   output logic              streaming,
   output logic              idle
);
   localparam int HDR_W = 16 + ADDR_W;
   localparam int NIB   = HDR_W / 4;
   localparam int NIB_W = $clog2(NIB + 1);
   localparam int GAP_W = $clog2(CS_HIGH_CYC + 1);

   link_st_t         st;
   logic             ph, half, cs_q;
   logic [HDR_W-1:0] sh;
   logic [NIB_W-1:0] nib;
   logic [DCYC_W-1:0] dcnt;
   logic [GAP_W-1:0] gap;
   logic [3:0]       hi;

   assign sclk      = ph;
   assign cs_n      = cs_q;
   assign io_out    = sh[HDR_W-1 -: 4];
   assign io_oe     = (st == LK_HDR);
   assign streaming = (st == LK_HDR) || (st == LK_DUMMY) || (st == LK_DATA);
   assign idle      = (st == LK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= LK_IDLE;
         ph        <= 1'b0;
         half      <= 1'b0;
         cs_q      <= 1'b1;
         sh        <= '0;
         nib       <= '0;
         dcnt      <= '0;
         gap       <= '0;
         hi        <= '0;
         push      <= 1'b0;
         push_data <= '0;
      end else begin
         push <= 1'b0;
         if (release_req && streaming) begin
            st   <= LK_GAP;
            ph   <= 1'b0;
            cs_q <= 1'b1;
            gap  <= '0;
            sh   <= '0;
         end else begin
            case (st)
               LK_IDLE: if (start) begin
                  cs_q <= 1'b0;
                  ph   <= 1'b0;
                  half <= 1'b0;
                  st   <= LK_HDR;
                  if (send_cmd) begin
                     sh  <= {READ_CMD, start_addr, MODE_BITS};
                     nib <= NIB_W'(NIB);
                  end else begin
                     sh  <= {start_addr, MODE_BITS, 8'h00};
                     nib <= NIB_W'(NIB - 2);
                  end
               end
               LK_HDR: if (!ph) ph <= 1'b1;
               else begin
                  ph   <= 1'b0;
                  sh   <= sh << 4;
                  nib  <= nib - 1'b1;
                  dcnt <= dummy;
                  if (nib == NIB_W'(1)) st <= (dummy == '0) ? LK_DATA : LK_DUMMY;
               end
               LK_DUMMY: if (!ph) ph <= 1'b1;
               else begin
                  ph   <= 1'b0;
                  dcnt <= dcnt - 1'b1;
                  if (dcnt == DCYC_W'(1)) st <= LK_DATA;
               end
               LK_DATA: if (!ph) begin
                  if (room) ph <= 1'b1;
               end else begin
                  ph   <= 1'b0;
                  half <= !half;
                  if (!half) hi <= io_in;
                  else begin
                     push      <= 1'b1;
                     push_data <= {hi, io_in};
                  end
               end
               LK_GAP: if (gap == GAP_W'(CS_HIGH_CYC - 1)) st <= LK_IDLE;
                       else gap <= gap + 1'b1;
               default: st <= LK_IDLE;
            endcase
         end
      end
   end

   AST_SCLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n); // R2
   AST_STALL_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_DATA && !ph && !room && !release_req) |=> !sclk); // R4
endmodule

// File: rtl/qspi_xip_prefetch.sv
module qspi_xip_prefetch #(
   parameter int         ADDR_W      = 24,
   parameter int         FIFO_DEPTH  = 8,
   parameter int         DCYC_W      = 5,
   parameter int         TO_W        = 16,
   parameter int         CS_HIGH_CYC = 2,
   parameter int         DEF_DUMMY   = 4,
   parameter bit         HAS_TIMEOUT = 1'b1,
   parameter logic [7:0] READ_CMD    = 8'hEB,
   parameter logic [7:0] MODE_BITS   = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_once,
   input  logic [DCYC_W-1:0] cfg_dummy,
   input  logic              cfg_to_en,
   input  logic [TO_W-1:0]   cfg_to_limit,
   input  logic              abort,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic [7:0]        rdata,
   output logic              busy,
   output logic              sclk,
   output logic              cs_n,
   output logic [3:0]        io_out,
   output logic              io_oe,
   input  logic [3:0]        io_in
);
   if (ADDR_W % 4 != 0 || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be a multiple of 4 and at least 8");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (CS_HIGH_CYC < 1) begin : g_bad_gap
      $error("CS_HIGH_CYC must be at least 1");
   end

   logic              once_q, to_en_q, cmd_pend, ready_q;
   logic [DCYC_W-1:0] dummy_q;
   logic [TO_W-1:0]   to_lim_q;
   logic [ADDR_W-1:0] nxt_addr;
   logic [7:0]        rdata_q, head, push_data;
   logic              req_v, mismatch, to_hit, kill, start, hit;
   logic              streaming, link_idle, push, full, empty;

   assign req_v    = req && !ready_q;
   assign mismatch = streaming && req_v && (addr != nxt_addr);
   assign kill     = abort || cfg_wr || mismatch || to_hit;
   assign start    = link_idle && req_v && !abort && !cfg_wr;
   assign hit      = req_v && !kill && (addr == nxt_addr) && !empty;
   assign ready    = ready_q;
   assign rdata    = rdata_q;
   assign busy     = !cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         once_q   <= 1'b0;
         to_en_q  <= 1'b0;
         dummy_q  <= DCYC_W'(DEF_DUMMY);
         to_lim_q <= '0;
         cmd_pend <= 1'b1;
         nxt_addr <= '0;
         ready_q  <= 1'b0;
         rdata_q  <= '0;
      end else begin
         ready_q <= hit;
         if (hit) rdata_q <= head;
         if (start)    nxt_addr <= addr;
         else if (hit) nxt_addr <= nxt_addr + 1'b1;
         if (cfg_wr) begin
            once_q   <= cfg_once;
            to_en_q  <= cfg_to_en;
            dummy_q  <= cfg_dummy;
            to_lim_q <= cfg_to_limit;
            cmd_pend <= 1'b1;
         end else if (start && once_q) begin
            cmd_pend <= 1'b0;
         end
      end
   end

   if (HAS_TIMEOUT) begin : g_timer
      xip_idle_timer #(.TO_W(TO_W)) timer_i (
         .clk(clk), .rst_n(rst_n), .enable(to_en_q), .limit(to_lim_q),
         .run(streaming && !req), .expired(to_hit)
      );
   end else begin : g_no_timer
      assign to_hit = 1'b0;
   end

   xip_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .flush(kill), .push(push), .push_data(push_data),
      .pop(hit), .head(head), .full(full), .empty(empty)
   );

   xip_link #(
      .ADDR_W(ADDR_W), .DCYC_W(DCYC_W), .CS_HIGH_CYC(CS_HIGH_CYC),
      .READ_CMD(READ_CMD), .MODE_BITS(MODE_BITS)
   ) link_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(addr),
      .send_cmd(!once_q || cmd_pend), .dummy(dummy_q), .release_req(kill),
      .room(!full), .io_in(io_in), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
      .io_oe(io_oe), .push(push), .push_data(push_data), .streaming(streaming),
      .idle(link_idle)
   );

   AST_RELEASE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(kill)); // R9
   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready); // R11
   AST_READY_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $past(req)); // R11
   AST_SELECT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(start)); // R1
endmodule

// File: tb/qspi_xip_prefetch_tb.sv
module qspi_xip_prefetch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0, cfg_once = 1'b0, cfg_to_en = 1'b0, abort = 1'b0;
   logic [4:0]  cfg_dummy = 5'd4;
   logic [15:0] cfg_to_limit = 16'd0;
   logic        req = 1'b0;
   logic [23:0] addr = '0;
   logic        ready, busy, sclk, cs_n, io_oe;
   logic [7:0]  rdata;
   logic [3:0]  io_out;
   logic [3:0]  io_in = 4'h0;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   qspi_xip_prefetch dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_once(cfg_once),
      .cfg_dummy(cfg_dummy), .cfg_to_en(cfg_to_en), .cfg_to_limit(cfg_to_limit),
      .abort(abort), .req(req), .addr(addr), .ready(ready), .rdata(rdata),
      .busy(busy), .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
      .io_in(io_in)
   );

   function automatic logic [7:0] fb(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // flash model
   int          seq_cnt = 0, cmd_cnt = 0, pcnt = 0, hdr = 0, cmd_nib = 0, sclk_edges = 0;
   bit          expect_cmd = 1'b1, bench_once = 1'b0, cur_cmd = 1'b0;
   int          dummy_set = 4;
   logic [39:0] shreg = '0;
   logic [23:0] m_addr = '0;
   time         t_rise = 0, t_fall = 0;

   always @(negedge cs_n) begin
      seq_cnt++;
      t_fall  = $time;
      pcnt    = 0;
      cur_cmd = expect_cmd;
      cmd_nib = (cur_cmd ? 2 : 0) + 8;
      hdr     = cmd_nib + dummy_set;
      shreg   = '0;
   end

   always @(posedge cs_n) begin
      t_rise = $time;
      if (seq_cnt > 0 && bench_once) expect_cmd = 1'b0;
   end

   always @(posedge sclk) begin
      sclk_edges++;
      if (cs_n == 1'b0) begin
         pcnt++;
         if (pcnt <= cmd_nib) begin
            shreg = {shreg[35:0], io_out};
            chk(io_oe == 1'b1, "R1", "io_oe during header", io_oe, 1);
         end else if (pcnt > hdr) begin
            chk(io_oe == 1'b0, "R1", "io_oe during data", io_oe, 0);
         end
         if (pcnt == cmd_nib) begin
            m_addr = shreg[31:8];
            chk(shreg[7:0] == 8'hA0, "R1", "continuation byte", shreg[7:0], 8'hA0);
            if (cur_cmd) begin
               cmd_cnt++;
               chk(shreg[39:32] == 8'hEB, "R5", "command byte", shreg[39:32], 8'hEB);
            end
         end
      end
   end

   always @(negedge sclk) begin
      if (cs_n == 1'b0 && pcnt >= hdr) begin
         automatic int k = pcnt - hdr;
         automatic logic [7:0] b = fb(m_addr + 24'(k / 2));
         io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && ready) begin
         if (exp_q.size() == 0) chk(1'b0, "R11", "ready without request", 1, 0);
         else begin
            automatic logic [7:0] e = exp_q.pop_front();
            chk(rdata == e, "R1", "read data", rdata, e);
         end
      end
   end

   task automatic rd(input logic [23:0] a);
      @(negedge clk);
      exp_q.push_back(fb(a));
      req  = 1'b1;
      addr = a;
      do @(negedge clk); while (!ready);
      req = 1'b0;
   endtask

   task automatic configure(input bit once, input int dum, input bit to_en, input int lim);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_once = once; cfg_dummy = 5'(dum);
      cfg_to_en = to_en; cfg_to_limit = 16'(lim);
      @(negedge clk);
      cfg_wr = 1'b0;
      repeat (2) @(negedge clk);
      bench_once = once; dummy_set = dum; expect_cmd = 1'b1;
   endtask

   bit done = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R1", "watchdog expired", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int s0, e0, c0;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 1'b0 && ready == 1'b0 && busy == 1'b0,
          "R10", "reset outputs", {cs_n, sclk, io_oe, ready, busy}, 5'b10000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5: command once, R1 basic read with 4 turnaround cycles
      configure(1'b1, 4, 1'b0, 0);
      rd(24'h000100);
      chk(seq_cnt == 1 && cmd_cnt == 1, "R5", "first transaction carries command", cmd_cnt, 1);
      chk(busy == 1'b1, "R9", "busy while open", busy, 1);

      // R4: stall once the queue is full
      repeat (200) @(negedge clk);
      e0 = sclk_edges;
      repeat (60) @(negedge clk);
      chk(sclk_edges == e0, "R4", "sclk edges during full stall", sclk_edges - e0, 0);
      chk(cs_n == 1'b0, "R7", "no release with timeout disabled", cs_n, 0);

      // R3: consecutive run served without a new command
      s0 = seq_cnt;
      for (int i = 1; i <= 16; i++) rd(24'h000100 + 24'(i));
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "all consecutive reads answered", exp_q.size(), 0);
      chk(seq_cnt == s0, "R3", "no new transaction in run", seq_cnt, s0);

      // R6: sequence break restarts without command
      c0 = cmd_cnt;
      rd(24'h002040);
      chk(seq_cnt == s0 + 1, "R6", "new transaction on jump", seq_cnt, s0 + 1);
      chk((t_fall - t_rise) / 4 >= 2, "R6", "cs_n high cycles", 32'((t_fall - t_rise) / 4), 2);
      chk(cmd_cnt == c0, "R5", "no command after first", cmd_cnt, c0);
      rd(24'h002041);

      // R8: abort releases select
      @(negedge clk); abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      chk(cs_n == 1'b1 && busy == 1'b0, "R8", "abort releases cs_n", cs_n, 1);
      rd(24'h002042);
      chk(cmd_cnt == c0, "R5", "no command after abort", cmd_cnt, c0);

      // R8 and R7: configuration write closes, timeout enabled
      @(negedge clk); cfg_wr = 1'b1; cfg_once = 1'b1; cfg_to_en = 1'b1; cfg_to_limit = 16'd40;
      @(negedge clk); cfg_wr = 1'b0;
      chk(cs_n == 1'b1, "R8", "config write releases cs_n", cs_n, 1);
      repeat (2) @(negedge clk);
      bench_once = 1'b1; expect_cmd = 1'b1;
      c0 = cmd_cnt;
      rd(24'h000400);
      chk(cmd_cnt == c0 + 1, "R5", "command again after config write", cmd_cnt, c0 + 1);
      repeat (120) @(negedge clk);
      chk(cs_n == 1'b1, "R7", "timeout released cs_n", cs_n, 1);
      s0 = seq_cnt;
      rd(24'h000401);
      chk(seq_cnt == s0 + 1 && cmd_cnt == c0 + 1, "R7", "reopen after timeout without command",
          seq_cnt, s0 + 1);

      // R5: command in every transaction when option clear, R1 with 6 turnaround cycles
      configure(1'b0, 6, 1'b0, 0);
      c0 = cmd_cnt;
      rd(24'h05555A);
      rd(24'h05555B);
      rd(24'h000900);
      rd(24'hFFFFFF);
      chk(cmd_cnt == c0 + 3, "R5", "command per transaction", cmd_cnt, c0 + 3);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R11", "no pending expectations", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule